// File: doc/BRIEF.md
# Oversampling Clock Enable Generator

This block runs entirely on the master clock of an audio converter. The master clock is a fixed multiple of the audio sample rate. From it, the block derives a single-cycle enable that paces the delta-sigma modulator at its oversampling rate. It also derives a once-per-sample strobe that is phase-aligned with that enable. Both outputs are enables in the master clock domain, not derived clocks. Logic downstream keeps running on the master clock and advances only in cycles where the enable is high.

Two static settings control the block. A speed select picks normal speed, where the modulator runs at 128 times the sample rate, or double speed, where it runs at 64 times the sample rate. A two-bit ratio code picks one of the four master clock multiples allowed in that speed. Because each allowed multiple is 2, 3, 4 or 6 times the oversampling rate, the enable divider uses the same four divide factors in both speeds. Only the number of enables per sample changes with speed.

The settings are captured once, on the first clock edge after the active-low power-down input is released. After that, a new setting takes effect only through another power-down cycle.

Top module: `osr_en_gen`

## Requirements
- R1: While `rst_n_i` is low, `os_en_o` and `smp_stb_o` are both low.
- R2: In normal speed (`dbl_speed_i` = 0), ratio codes 0, 1, 2 and 3 select master clock multiples of 256, 384, 512 and 768. `os_en_o` is high for exactly one cycle in every 2, 3, 4 or 6 cycles respectively.
- R3: In double speed (`dbl_speed_i` = 1), ratio codes 0, 1, 2 and 3 select multiples of 128, 192, 256 and 384. `os_en_o` pulses once every 2, 3, 4 or 6 cycles respectively.
- R4: Count the rising clock edges from the first one at which `rst_n_i` is high. The first `os_en_o` pulse is visible just after edge number D, where D is the divide factor.
- R5: In normal speed, `smp_stb_o` pulses once every 128 enables. The first strobe is visible after edge 128·D, and strobes then repeat every 128·D cycles (the full master clock multiple).
- R6: In double speed, `smp_stb_o` pulses once every 64 enables. The first strobe is visible after edge 64·D, and strobes then repeat every 64·D cycles.
- R7: `smp_stb_o` is high only in cycles where `os_en_o` is also high.
- R8: Changes to `dbl_speed_i` or `ratio_sel_i` after reset release have no effect on the enable or strobe timing.
- R9: Asserting `rst_n_i` low in the middle of a count restarts both counters. The settings present at the next release are used, and timing follows R4 to R6 from that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Active-low power-down; holds the block in reset |
| dbl_speed_i | input | 1 | Speed select: 0 normal, 1 double |
| ratio_sel_i | input | 2 | Master clock multiple code, ascending within the speed |
| os_en_o | output | 1 | Single-cycle oversampling enable |
| smp_stb_o | output | 1 | Once-per-sample strobe, coincident with an enable |

## Verification
The main function is exercised with all eight combinations of speed and ratio code. Each run measures the latency to the first enable, every gap between enables, and the positions of the first two strobes. The four ratio codes separate the divide decode from one another. The two speeds share divide factors, so only the strobe position tells them apart, and that exposes a wrong enables-per-sample limit. A run where both settings change a few cycles after release shows whether the settings are latched or followed live. A reset in the middle of a count, followed by release with different settings, shows whether both counters restart from zero and pick up the new settings.

// File: rtl/osr_pkg.sv
package osr_pkg;

    typedef logic [2:0] div_t;

    typedef struct packed {
        logic run;
        logic dbl;
        div_t div;
    } cfg_t;

    // Master clock multiple over oversampling rate; identical in both speeds.
    function automatic div_t ratio_to_div(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd2;
            2'd1:    return 3'd3;
            2'd2:    return 3'd4;
            default: return 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/osr_cfg_capture.sv
module osr_cfg_capture
    import osr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       dbl_speed_i,
    input  logic [1:0] ratio_sel_i,
    output cfg_t       cfg_o
);

    cfg_t cfg_d, cfg_q;

    // Settings are taken only on the first edge after release, then frozen.
    always_comb begin
        cfg_d = cfg_q;
        if (!cfg_q.run) begin
            cfg_d.run = 1'b1;
            cfg_d.dbl = dbl_speed_i;
            cfg_d.div = ratio_to_div(ratio_sel_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cfg_q <= '0;
        else          cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/osr_phase_div.sv
module osr_phase_div
    import osr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    input  div_t div_i,
    output logic tick_o
);

    div_t phase_d, phase_q;
    logic at_end;

    assign at_end = (phase_q == div_i - 3'd1);
    assign tick_o = run_i && at_end;

    always_comb begin
        phase_d = phase_q;
        if (!run_i)      phase_d = '0;
        else if (at_end) phase_d = '0;
        else             phase_d = phase_q + 3'd1;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) phase_q <= '0;
        else          phase_q <= phase_d;
    end

endmodule

// File: rtl/osr_sample_cnt.sv
module osr_sample_cnt #(
    parameter int OSR_NORM = 128
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    input  logic dbl_i,
    input  logic tick_i,
    output logic stb_o
);

    localparam int CNT_W = $clog2(OSR_NORM);
    localparam logic [CNT_W-1:0] LAST_NORM = CNT_W'(OSR_NORM - 1);
    localparam logic [CNT_W-1:0] LAST_DBL  = CNT_W'(OSR_NORM / 2 - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    assign last  = dbl_i ? LAST_DBL : LAST_NORM;
    assign stb_o = tick_i && (cnt_q == last);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)     cnt_d = '0;
        else if (stb_o) cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) cnt_q <= '0;
        else          cnt_q <= cnt_d;
    end

endmodule

// File: rtl/osr_en_gen.sv
module osr_en_gen #(
    parameter int OSR_NORM = 128
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       dbl_speed_i,
    input  logic [1:0] ratio_sel_i,
    output logic       os_en_o,
    output logic       smp_stb_o
);

    osr_pkg::cfg_t cfg;

    osr_cfg_capture u_cfg (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .dbl_speed_i (dbl_speed_i),
        .ratio_sel_i (ratio_sel_i),
        .cfg_o       (cfg)
    );

    osr_phase_div u_div (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (cfg.run),
        .div_i   (cfg.div),
        .tick_o  (os_en_o)
    );

    osr_sample_cnt #(.OSR_NORM(OSR_NORM)) u_smp (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (cfg.run),
        .dbl_i   (cfg.dbl),
        .tick_i  (os_en_o),
        .stb_o   (smp_stb_o)
    );

endmodule

// File: rtl/osr_en_gen_chk.sv
module osr_en_gen_chk #(
    parameter int OSR_NORM = 128
) (
    input logic       clk_i,
    input logic       rst_n_i,
    input logic       os_en_o,
    input logic       smp_stb_o,
    input logic       run_i,
    input logic       dbl_i,
    input logic [2:0] div_i
);

    localparam int CNT_W = $clog2(OSR_NORM) + 1;
    localparam logic [CNT_W-1:0] LIM_NORM = CNT_W'(OSR_NORM - 1);
    localparam logic [CNT_W-1:0] LIM_DBL  = CNT_W'(OSR_NORM / 2 - 1);

    logic [2:0]       gap_q;
    logic [CNT_W-1:0] en_cnt_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            gap_q    <= '0;
            en_cnt_q <= '0;
        end else begin
            gap_q <= (!run_i || os_en_o) ? 3'd0 : gap_q + 3'd1;
            if (!run_i || smp_stb_o) en_cnt_q <= '0;
            else if (os_en_o)        en_cnt_q <= en_cnt_q + 1'b1;
        end
    end

    p_quiet_in_reset_r1: assert property (@(posedge clk_i)
        !rst_n_i |-> (!os_en_o && !smp_stb_o));

    // R2 and R3 (gap from run start also covers R4)
    p_en_gap_r2_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        os_en_o |-> (gap_q == div_i - 3'd1));

    p_en_single_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        os_en_o |=> !os_en_o);

    p_stb_count_r5_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        smp_stb_o |-> (en_cnt_q == (dbl_i ? LIM_DBL : LIM_NORM)));

    p_stb_on_en_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        smp_stb_o |-> os_en_o);

    p_cfg_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (run_i && $past(run_i)) |-> ($stable(div_i) && $stable(dbl_i)));

endmodule

bind osr_en_gen osr_en_gen_chk #(.OSR_NORM(OSR_NORM)) u_chk (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .os_en_o   (os_en_o),
    .smp_stb_o (smp_stb_o),
    .run_i     (cfg.run),
    .dbl_i     (cfg.dbl),
    .div_i     (cfg.div)
);

// File: tb/osr_en_gen_tb.sv
module osr_en_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbl = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       os_en, smp_stb;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    osr_en_gen dut_i (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .dbl_speed_i (dbl),
        .ratio_sel_i (sel),
        .os_en_o     (os_en),
        .smp_stb_o   (smp_stb)
    );

    // {speed, ratio code, expected divide}
    localparam logic [5:0] VEC [0:7] = '{
        {1'b0, 2'd0, 3'd2}, {1'b0, 2'd1, 3'd3}, {1'b0, 2'd2, 3'd4}, {1'b0, 2'd3, 3'd6},
        {1'b1, 2'd0, 3'd2}, {1'b1, 2'd1, 3'd3}, {1'b1, 2'd2, 3'd4}, {1'b1, 2'd3, 3'd6}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Reset, load settings, release, then measure two sample periods.
    task automatic run_cfg(input logic d, input logic [1:0] s, input int div,
                           input bit flip, input string rq);
        int ratio, first_en, prev, gap_bad, stb1, stb2, orphan, quiet_bad;
        ratio = div * (d ? 64 : 128);
        first_en = -1; prev = -1; gap_bad = 0; stb1 = -1; stb2 = -1;
        orphan = 0; quiet_bad = 0;
        @(negedge clk);
        rst_n = 1'b0; dbl = d; sel = s;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (os_en || smp_stb) quiet_bad++;
        end
        check(quiet_bad == 0, {rq, " R1 quiet in reset"}, quiet_bad, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= 2 * ratio + 2; k++) begin
            @(negedge clk);
            if (os_en) begin
                if (first_en < 0) first_en = k;
                else if (k - prev != div) gap_bad++;
                prev = k;
            end
            if (smp_stb) begin
                if (!os_en) orphan++;
                if (stb1 < 0) stb1 = k;
                else if (stb2 < 0) stb2 = k;
            end
            if (flip && k == 10) begin
                dbl = ~d;
                sel = s + 2'd1;
            end
        end
        check(first_en == div, {rq, " R4 first enable"}, first_en, div);
        check(gap_bad == 0, {rq, d ? " R3 enable gaps" : " R2 enable gaps"}, gap_bad, 0);
        check(stb1 == ratio, {rq, d ? " R6 first strobe" : " R5 first strobe"}, stb1, ratio);
        check(stb2 == 2 * ratio, {rq, d ? " R6 second strobe" : " R5 second strobe"}, stb2, 2 * ratio);
        check(orphan == 0, {rq, " R7 strobe without enable"}, orphan, 0);
    endtask

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state at power-up
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!os_en && !smp_stb, "R1 outputs low at power-up", {os_en, smp_stb}, 0);
        end

        foreach (VEC[i]) begin
            run_cfg(VEC[i][5], VEC[i][4:3], int'(VEC[i][2:0]), 1'b0, "vec");
        end

        // R8: settings flipped while running have no effect
        run_cfg(1'b0, 2'd0, 2, 1'b1, "R8 live change");
        run_cfg(1'b1, 2'd2, 4, 1'b1, "R8 live change");

        // R9: reset partway through a count, restart with new settings
        @(negedge clk);
        rst_n = 1'b0; dbl = 1'b0; sel = 2'd1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (37) @(negedge clk);
        run_cfg(1'b1, 2'd3, 6, 1'b0, "R9 restart");
        repeat (101) @(negedge clk);
        run_cfg(1'b0, 2'd2, 4, 1'b0, "R9 restart");

        finish_run();
    end

endmodule